// File: doc/BRIEF.md
# Pointer Data Address Generator

This block turns a 16-bit pointer value into the data-space address of a load or store operand. It also computes the pointer value to be written back when the access mode changes the pointer. The caller presents the current contents of the chosen pointer, a code naming that pointer, an access-mode code and a 6-bit unsigned offset, and pulses a start strobe. One clock later the block presents the operand address, the updated pointer value, a write-enable that names the pointer to update, and an address-valid strobe. The registered address is ready for the first cycle of a two-cycle memory access.

Four access modes are supported. Plain indirect uses the pointer as it is. Offset mode adds the 6-bit offset to the pointer. Decrement-before-use lowers the pointer by one and uses the lowered value. Increment-after-use uses the old value and then raises the pointer by one. The register file that holds the pointers, the memory and the instruction decoder are outside the block. A request that the block cannot serve is flagged as illegal, and it produces neither an access nor a write-back.

Top module: `ptr_agen`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `addr_o`, `new_ptr_o`, `wr_sel_o`, `wr_en_o`, `valid_o` and `illegal_o` are all zero.
- R2: Mode code 0 (plain) gives `addr_o` = `new_ptr_o` = `ptr_val_i`, with `wr_en_o` = 0.
- R3: Mode code 1 (offset) gives `addr_o` = `ptr_val_i` + zero-extended `disp_i` (0..63), with `new_ptr_o` = `ptr_val_i` and `wr_en_o` = 0. It is legal only for pointer codes 1 and 2.
- R4: Mode code 2 (decrement-before-use) gives `addr_o` = `new_ptr_o` = `ptr_val_i` − 1, with `wr_en_o` = 1.
- R5: Mode code 3 (increment-after-use) gives `addr_o` = `ptr_val_i` and `new_ptr_o` = `ptr_val_i` + 1, with `wr_en_o` = 1.
- R6: All pointer and address arithmetic wraps modulo 2^16. Examples: 0x0000 − 1 = 0xFFFF, 0xFFFF + 1 = 0x0000, and 0xFFFF + 1 (offset) = 0x0000.
- R7: On a legal request, `wr_sel_o` takes the request's pointer code (0 = X, 1 = Y, 2 = Z). `wr_en_o` is never high without `valid_o`.
- R8: Mode 1 with pointer code 0, or any request with pointer code 3, is illegal. It sets `illegal_o` = 1 and `valid_o` = `wr_en_o` = 0, and it leaves `addr_o`, `new_ptr_o` and `wr_sel_o` unchanged.
- R9: Outputs appear on the clock edge after the one that samples `start_i`. A cycle without `start_i` gives `valid_o` = `wr_en_o` = `illegal_o` = 0 on the next cycle. Back-to-back starts each produce their own result.
- R10: Without `start_i`, `addr_o`, `new_ptr_o` and `wr_sel_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request strobe, one cycle per request |
| ptr_sel_i | input | 2 | Pointer code: 0 X, 1 Y, 2 Z, 3 none |
| mode_i | input | 2 | Mode: 0 plain, 1 offset, 2 decrement-before, 3 increment-after |
| disp_i | input | 6 | Unsigned offset for mode 1 |
| ptr_val_i | input | 16 | Current contents of the selected pointer |
| addr_o | output | 16 | Operand address |
| new_ptr_o | output | 16 | Pointer value to write back |
| wr_sel_o | output | 2 | Pointer code to update |
| wr_en_o | output | 1 | Pointer write-back enable |
| valid_o | output | 1 | Address valid strobe |
| illegal_o | output | 1 | Illegal request flag |

## Verification
On every cycle, the checker relates each registered output to the request sampled one edge earlier. It checks the address and write-back arithmetic of every mode, the rejection of illegal combinations, the quiet outputs on idle cycles, and the holding of the address and pointer outputs. Only the bench scenarios can show particular wrap-around values at the ends of the address range, the offset extremes of 0 and 63, and the held values after an illegal request. They also cover reset taken in the middle of a run and exact results for back-to-back requests.

// File: rtl/ptr_agen_pkg.sv
package ptr_agen_pkg;
  typedef enum logic [1:0] {
    PS_X    = 2'd0,
    PS_Y    = 2'd1,
    PS_Z    = 2'd2,
    PS_NONE = 2'd3
  } ptr_code_e;

  typedef enum logic [1:0] {
    AM_PLAIN   = 2'd0,
    AM_OFFSET  = 2'd1,
    AM_DECPRE  = 2'd2,
    AM_INCPOST = 2'd3
  } acc_mode_e;
endpackage

// File: rtl/agen_legal.sv
module agen_legal
  import ptr_agen_pkg::*;
(
  input  logic [1:0] sel_i,
  input  logic [1:0] mode_i,
  output logic       legal_o,
  output logic       upd_o
);
  ptr_code_e sel_e;
  acc_mode_e mode_e;

  always_comb begin
    sel_e  = ptr_code_e'(sel_i);
    mode_e = acc_mode_e'(mode_i);
    legal_o = 1'b1;
    if (sel_e == PS_NONE) legal_o = 1'b0;
    if (mode_e == AM_OFFSET && sel_e == PS_X) legal_o = 1'b0;
    upd_o = (mode_e == AM_DECPRE) || (mode_e == AM_INCPOST);
  end
endmodule

// File: rtl/agen_calc.sv
module agen_calc
  import ptr_agen_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 6
) (
  input  logic [1:0]    mode_i,
  input  logic [AW-1:0] ptr_i,
  input  logic [DW-1:0] disp_i,
  output logic [AW-1:0] ea_o,
  output logic [AW-1:0] np_o
);
  localparam int PADW = AW - DW;

  logic [AW-1:0] disp_ext;
  logic [AW-1:0] ptr_dec;
  logic [AW-1:0] ptr_inc;
  logic [AW-1:0] ptr_off;

  assign disp_ext = {{PADW{1'b0}}, disp_i};
  assign ptr_dec  = ptr_i - AW'(1);
  assign ptr_inc  = ptr_i + AW'(1);
  assign ptr_off  = ptr_i + disp_ext;

  always_comb begin
    ea_o = ptr_i;
    np_o = ptr_i;
    unique case (acc_mode_e'(mode_i))
      AM_PLAIN:   begin ea_o = ptr_i;   np_o = ptr_i;   end
      AM_OFFSET:  begin ea_o = ptr_off; np_o = ptr_i;   end
      AM_DECPRE:  begin ea_o = ptr_dec; np_o = ptr_dec; end
      AM_INCPOST: begin ea_o = ptr_i;   np_o = ptr_inc; end
      default:    begin ea_o = ptr_i;   np_o = ptr_i;   end
    endcase
  end
endmodule

// File: rtl/agen_oreg.sv
module agen_oreg #(
  parameter int AW = 16,
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          legal_i,
  input  logic          upd_i,
  input  logic [SW-1:0] sel_i,
  input  logic [AW-1:0] ea_i,
  input  logic [AW-1:0] np_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] new_ptr_o,
  output logic [SW-1:0] wr_sel_o,
  output logic          wr_en_o,
  output logic          valid_o,
  output logic          illegal_o
);
  logic accept;
  assign accept = start_i && legal_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o    <= '0;
      new_ptr_o <= '0;
      wr_sel_o  <= '0;
    end else if (accept) begin
      addr_o    <= ea_i;
      new_ptr_o <= np_i;
      wr_sel_o  <= sel_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en_o   <= 1'b0;
      valid_o   <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      valid_o   <= accept;
      wr_en_o   <= accept && upd_i;
      illegal_o <= start_i && !legal_i;
    end
  end
endmodule

// File: rtl/ptr_agen.sv
module ptr_agen #(
  parameter int AW = 16,
  parameter int DW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [1:0]    ptr_sel_i,
  input  logic [1:0]    mode_i,
  input  logic [DW-1:0] disp_i,
  input  logic [AW-1:0] ptr_val_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] new_ptr_o,
  output logic [1:0]    wr_sel_o,
  output logic          wr_en_o,
  output logic          valid_o,
  output logic          illegal_o
);
  localparam int SW = 2;

  logic          legal;
  logic          upd;
  logic [AW-1:0] ea;
  logic [AW-1:0] np;

  agen_legal u_legal (
    .sel_i   (ptr_sel_i),
    .mode_i  (mode_i),
    .legal_o (legal),
    .upd_o   (upd)
  );

  agen_calc #(.AW(AW), .DW(DW)) u_calc (
    .mode_i (mode_i),
    .ptr_i  (ptr_val_i),
    .disp_i (disp_i),
    .ea_o   (ea),
    .np_o   (np)
  );

  agen_oreg #(.AW(AW), .SW(SW)) u_oreg (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .legal_i   (legal),
    .upd_i     (upd),
    .sel_i     (ptr_sel_i),
    .ea_i      (ea),
    .np_i      (np),
    .addr_o    (addr_o),
    .new_ptr_o (new_ptr_o),
    .wr_sel_o  (wr_sel_o),
    .wr_en_o   (wr_en_o),
    .valid_o   (valid_o),
    .illegal_o (illegal_o)
  );
endmodule

// File: rtl/ptr_agen_chk.sv
module ptr_agen_chk #(
  parameter int AW = 16,
  parameter int DW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          start_i,
  input logic [1:0]    ptr_sel_i,
  input logic [1:0]    mode_i,
  input logic [DW-1:0] disp_i,
  input logic [AW-1:0] ptr_val_i,
  input logic [AW-1:0] addr_o,
  input logic [AW-1:0] new_ptr_o,
  input logic [1:0]    wr_sel_o,
  input logic          wr_en_o,
  input logic          valid_o,
  input logic          illegal_o
);
  logic armed;
  logic req_bad;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  assign req_bad = (ptr_sel_i == 2'd3) || (mode_i == 2'd1 && ptr_sel_i == 2'd0);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) $past(rst) |-> (!valid_o && !wr_en_o && !illegal_o && addr_o == '0));

  // R2
  plain_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(start_i) && !$past(req_bad) && $past(mode_i) == 2'd0)
    |-> (addr_o == $past(ptr_val_i) && new_ptr_o == $past(ptr_val_i) && !wr_en_o));

  // R3
  offset_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(start_i) && !$past(req_bad) && $past(mode_i) == 2'd1)
    |-> (addr_o == AW'($past(ptr_val_i) + AW'($past(disp_i))) && new_ptr_o == $past(ptr_val_i) && !wr_en_o));

  // R4
  decpre_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(start_i) && !$past(req_bad) && $past(mode_i) == 2'd2)
    |-> (addr_o == AW'($past(ptr_val_i) - 1'b1) && new_ptr_o == addr_o && wr_en_o));

  // R5
  incpost_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(start_i) && !$past(req_bad) && $past(mode_i) == 2'd3)
    |-> (addr_o == $past(ptr_val_i) && new_ptr_o == AW'($past(ptr_val_i) + 1'b1) && wr_en_o));

  // R7
  wr_sel_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    valid_o |-> (wr_sel_o == $past(ptr_sel_i)));

  // R7
  wr_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> valid_o);

  // R8
  illegal_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(start_i) && $past(req_bad))
    |-> (illegal_o && !valid_o && !wr_en_o && $stable(addr_o) && $stable(new_ptr_o)));

  // R9
  idle_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    !$past(start_i) |-> (!valid_o && !wr_en_o && !illegal_o));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    !$past(start_i) |-> ($stable(addr_o) && $stable(new_ptr_o) && $stable(wr_sel_o)));
endmodule

bind ptr_agen ptr_agen_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start_i   (start_i),
  .ptr_sel_i (ptr_sel_i),
  .mode_i    (mode_i),
  .disp_i    (disp_i),
  .ptr_val_i (ptr_val_i),
  .addr_o    (addr_o),
  .new_ptr_o (new_ptr_o),
  .wr_sel_o  (wr_sel_o),
  .wr_en_o   (wr_en_o),
  .valid_o   (valid_o),
  .illegal_o (illegal_o)
);

// File: tb/sim_ptr_agen.sv
`timescale 1ns/1ps
module sim_ptr_agen;
  localparam int AW = 16;
  localparam int DW = 6;
  localparam int NV = 12;
  localparam int VW = 63;

  logic          clk = 1'b0;
  logic          rst;
  logic          start_i;
  logic [1:0]    ptr_sel_i;
  logic [1:0]    mode_i;
  logic [DW-1:0] disp_i;
  logic [AW-1:0] ptr_val_i;
  logic [AW-1:0] addr_o;
  logic [AW-1:0] new_ptr_o;
  logic [1:0]    wr_sel_o;
  logic          wr_en_o;
  logic          valid_o;
  logic          illegal_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  ptr_agen #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .ptr_sel_i(ptr_sel_i),
    .mode_i(mode_i), .disp_i(disp_i), .ptr_val_i(ptr_val_i),
    .addr_o(addr_o), .new_ptr_o(new_ptr_o), .wr_sel_o(wr_sel_o),
    .wr_en_o(wr_en_o), .valid_o(valid_o), .illegal_o(illegal_o)
  );

  // fields: sel, mode, disp, ptr | exp addr, exp new, exp wsel, we, valid, illegal
  localparam logic [VW-1:0] TAB [NV] = '{
    {2'd0, 2'd0, 6'd0,  16'h1234, 16'h1234, 16'h1234, 2'd0, 1'b0, 1'b1, 1'b0}, // R2
    {2'd1, 2'd1, 6'd63, 16'h1000, 16'h103F, 16'h1000, 2'd1, 1'b0, 1'b1, 1'b0}, // R3 max offset
    {2'd2, 2'd1, 6'd0,  16'hABCD, 16'hABCD, 16'hABCD, 2'd2, 1'b0, 1'b1, 1'b0}, // R3 zero offset
    {2'd2, 2'd1, 6'd1,  16'hFFFF, 16'h0000, 16'hFFFF, 2'd2, 1'b0, 1'b1, 1'b0}, // R6 offset wrap
    {2'd0, 2'd2, 6'd9,  16'h0010, 16'h000F, 16'h000F, 2'd0, 1'b1, 1'b1, 1'b0}, // R4
    {2'd1, 2'd2, 6'd0,  16'h0000, 16'hFFFF, 16'hFFFF, 2'd1, 1'b1, 1'b1, 1'b0}, // R6 dec wrap
    {2'd2, 2'd3, 6'd0,  16'h2000, 16'h2000, 16'h2001, 2'd2, 1'b1, 1'b1, 1'b0}, // R5
    {2'd0, 2'd3, 6'd0,  16'hFFFF, 16'hFFFF, 16'h0000, 2'd0, 1'b1, 1'b1, 1'b0}, // R6 inc wrap
    {2'd0, 2'd1, 6'd5,  16'h4444, 16'hFFFF, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b1}, // R8 offset on X
    {2'd3, 2'd0, 6'd0,  16'h5555, 16'hFFFF, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b1}, // R8 code 3
    {2'd1, 2'd3, 6'd0,  16'h7FFF, 16'h7FFF, 16'h8000, 2'd1, 1'b1, 1'b1, 1'b0}, // R7 sel Y
    {2'd2, 2'd0, 6'd0,  16'h00FF, 16'h00FF, 16'h00FF, 2'd2, 1'b0, 1'b1, 1'b0}  // R7 sel Z
  };

  function automatic logic [36:0] outs();
    return {addr_o, new_ptr_o, wr_sel_o, wr_en_o, valid_o, illegal_o};
  endfunction

  task automatic check(input string tag, input logic [36:0] got, input logic [36:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [1:0] s, input logic [1:0] m, input logic [5:0] d, input logic [15:0] p);
    start_i = 1'b1; ptr_sel_i = s; mode_i = m; disp_i = d; ptr_val_i = p;
  endtask

  initial begin
    rst = 1'b1; start_i = 1'b0; ptr_sel_i = '0; mode_i = '0; disp_i = '0; ptr_val_i = '0;
    repeat (3) @(negedge clk);
    check("R1 in reset", outs(), 37'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", outs(), 37'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(TAB[i][62:61], TAB[i][60:59], TAB[i][58:53], TAB[i][52:37]);
      @(negedge clk);
      start_i = 1'b0;
      check($sformatf("R2-R8 vector %0d", i), outs(), TAB[i][36:0]);
    end

    // R9 and R10: idle cycle drops strobes and holds data (last vector: 00FF/00FF/Z)
    @(negedge clk);
    check("R9 R10 idle hold", outs(), {16'h00FF, 16'h00FF, 2'd2, 1'b0, 1'b0, 1'b0});

    // R9: back-to-back requests
    @(negedge clk);
    drive(2'd1, 2'd2, 6'd0, 16'h0100);
    @(negedge clk);
    check("R9 first of pair", outs(), {16'h00FF, 16'h00FF, 2'd1, 1'b1, 1'b1, 1'b0});
    drive(2'd2, 2'd1, 6'd32, 16'h0200);
    @(negedge clk);
    start_i = 1'b0;
    check("R9 second of pair", outs(), {16'h0220, 16'h0200, 2'd2, 1'b0, 1'b1, 1'b0});

    // R8 then R10: illegal request keeps data, idle keeps it too
    @(negedge clk);
    drive(2'd0, 2'd1, 6'd63, 16'h9999);
    @(negedge clk);
    start_i = 1'b0;
    check("R8 illegal hold", outs(), {16'h0220, 16'h0200, 2'd2, 1'b0, 1'b0, 1'b1});
    @(negedge clk);
    check("R10 idle after illegal", outs(), {16'h0220, 16'h0200, 2'd2, 1'b0, 1'b0, 1'b0});

    // R1: reset in the middle of a run, with a request pending
    drive(2'd2, 2'd3, 6'd0, 16'h3000);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset", outs(), 37'd0);
    start_i = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check("R1 first cycle after reset", outs(), 37'd0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule